// File: doc/BRIEF.md
# Chip Interrupt Control and Status Register

This block is the chip-level interrupt control register of a peripheral chip. The host sees a 32-bit register as two 16-bit words on a simple synchronous register port. Register address 0 is the low word and register address 1 is the high word. The low word holds two host-written bits, an interrupt enable and an interrupt request. It also holds a read-only pending-status bit, which is the AND of those two.

The same pending condition drives an active-low status line toward the bus interface chip. A request that the host sets while the enable is clear stays hidden, both in the status bit and on the line, until the enable is also set. The high word and the upper thirteen bits of the low word carry no function.

Top module: `chip_irq_csr`

## Requirements
- R1: While rst_ni is low, and after it is released with no write, enable and request are 0, stat_no is 1, and a read of address 0 returns 0x0000.
- R2: A write (wr_i high) to address 0 loads wdata_i bit 0 into the enable bit on that clock edge; a read of address 0 returns it at rdata_o bit 0 from the next cycle on.
- R3: A write to address 0 loads wdata_i bit 1 into the request bit on that clock edge; a read of address 0 returns it at rdata_o bit 1 from the next cycle on.
- R4: A read of address 0 returns, at rdata_o bit 2, the AND of the stored enable and request bits.
- R5: stat_no is at all times the inverse of (enable AND request), so it is low only when both are 1.
- R6: Bits 15:3 of a read of address 0 are always 0, and values written to those bit positions have no effect on any read or on stat_no.
- R7: A read of address 1 returns 0x0000, and a write to address 1 leaves enable, request and stat_no unchanged.
- R8: rdata_o is 0x0000 in any cycle where rd_i is low or addr_i is neither 0 nor 1.
- R9: A write to any address other than 0 leaves enable, request and stat_no unchanged.
- R10: When a read and a write to address 0 fall in the same cycle, the read returns the value held before that edge, and the written value is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (4) | Register address |
| wdata_i | input | DATA_W (16) | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W (16) | Read data, valid in the cycle rd_i is high |
| stat_no | output | 1 | Interrupt pending, active low |

## Verification
A read and a write to address 0 can fall in the same cycle. The read must then show the bits held before the edge, and the written bits must appear only one cycle later. The bench drives rd_i and wr_i together with changing write patterns. It checks the combinational read data a quarter period after the inputs change, and it moves its reference model only at the clock edge. A pending request hidden by a cleared enable is also made to appear in the same edge that sets the enable, and stat_no is judged against the model in every cycle.

// File: rtl/chip_irq_csr_pkg.sv
package chip_irq_csr_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned REQ_BIT  = 1;
  localparam int unsigned PEND_BIT = 2;

  typedef struct packed {
    logic req;
    logic en;
  } irq_bits_t;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned LO_ADDR = 0,
  parameter int unsigned HI_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              we_lo_o,
  output logic              re_lo_o,
  output logic              re_hi_o
);
  localparam logic [ADDR_W-1:0] LoA = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HiA = ADDR_W'(HI_ADDR);

  logic hit_lo, hit_hi;
  assign hit_lo  = (addr_i == LoA);
  assign hit_hi  = (addr_i == HiA);
  assign we_lo_o = wr_i & hit_lo;
  assign re_lo_o = rd_i & hit_lo;
  assign re_hi_o = rd_i & hit_hi;
endmodule

// File: rtl/irq_bits.sv
module irq_bits
  import chip_irq_csr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic [1:0] wd_i,
  output irq_bits_t bits_o,
  output logic      pend_o
);
  irq_bits_t bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bits_q <= '0;
    else if (we_i) bits_q <= '{req: wd_i[REQ_BIT], en: wd_i[EN_BIT]};
  end

  assign bits_o = bits_q;
  assign pend_o = bits_q.en & bits_q.req;

  // R2/R3: a write loads both bits on its edge
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (bits_q.en == $past(wd_i[EN_BIT])) && (bits_q.req == $past(wd_i[REQ_BIT])));
  // R9: no write, no change
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(bits_q));
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux
  import chip_irq_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              re_lo_i,
  input  logic              re_hi_i,
  input  irq_bits_t         bits_i,
  input  logic              pend_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] lo_word;
  logic              unused_hi;

  // high word carries no function; its strobe only selects zeros
  assign unused_hi = re_hi_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == EN_BIT) begin : g_en
      assign lo_word[b] = bits_i.en;
    end else if (b == REQ_BIT) begin : g_req
      assign lo_word[b] = bits_i.req;
    end else if (b == PEND_BIT) begin : g_pend
      assign lo_word[b] = pend_i;
    end else begin : g_zero
      assign lo_word[b] = 1'b0;
    end
  end

  assign rdata_o = re_lo_i ? lo_word : '0;
endmodule

// File: rtl/chip_irq_csr.sv
module chip_irq_csr
  import chip_irq_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stat_no
);
  localparam int unsigned CtlBits = 2;

  logic      we_lo, re_lo, re_hi, pend;
  irq_bits_t bits;
  logic      unused_wd;

  assign unused_wd = ^wdata_i[DATA_W-1:CtlBits];

  csr_addr_dec #(.ADDR_W(ADDR_W), .LO_ADDR(0), .HI_ADDR(1)) u_dec (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .we_lo_o(we_lo),
    .re_lo_o(re_lo),
    .re_hi_o(re_hi)
  );

  irq_bits u_bits (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we_lo),
    .wd_i  (wdata_i[CtlBits-1:0]),
    .bits_o(bits),
    .pend_o(pend)
  );

  csr_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .re_lo_i(re_lo),
    .re_hi_i(re_hi),
    .bits_i (bits),
    .pend_i (pend),
    .rdata_o(rdata_o)
  );

  assign stat_no = ~pend;

  // R5/R4: status line agrees with the readable pending bit
  assert_stat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == '0) |-> (rdata_o[PEND_BIT] == !stat_no));
  assert_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == '0) |-> (rdata_o[PEND_BIT] == (rdata_o[EN_BIT] & rdata_o[REQ_BIT])));
  assert_unalloc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:PEND_BIT+1] == '0);
  assert_hiword_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(1)) |-> (rdata_o == '0));
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
  assert_rst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> stat_no);
endmodule

// File: tb/chip_irq_csr_tb.sv
module chip_irq_csr_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              wr = 0, rd = 0;
  logic [DATA_W-1:0] rdata;
  logic              stat_n;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_en = 0, m_req = 0;

  always #(CLK_P/2) clk = ~clk;

  chip_irq_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .stat_no(stat_n)
  );

  function automatic logic [DATA_W-1:0] exp_rd(input int a, input bit r);
    if (r && a == 0) return DATA_W'({m_en & m_req, m_req, m_en});
    return '0;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, move model at posedge
  task automatic cyc(input string req, input int a, input logic [DATA_W-1:0] d,
                     input bit w, input bit r);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr = w; rd = r;
    #(CLK_P/4);
    check({req, " rdata"}, rdata, exp_rd(a, r));
    check("R5 stat_no", DATA_W'(stat_n), DATA_W'(!(m_en & m_req)));
    @(posedge clk);
    if (w && a == 0) begin m_en = d[0]; m_req = d[1]; end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: during reset
    rd = 1; addr = '0;
    #(CLK_P*2 + CLK_P/4);
    check("R1 reset rdata", rdata, 16'h0000);
    check("R1 reset stat_no", DATA_W'(stat_n), 16'h0001);
    @(negedge clk); rst_n = 1;
    cyc("R1 post-reset read", 0, '0, 0, 1);

    // R3: request alone stays hidden
    cyc("R3", 0, 16'h0002, 1, 0);
    cyc("R3 req only", 0, '0, 0, 1);
    // R10: set enable while reading same cycle -> old value shown
    cyc("R10 rd+wr", 0, 16'h0003, 1, 1);
    cyc("R4 pend", 0, '0, 0, 1);
    // R7: high word write/read
    cyc("R7 hi write", 1, 16'h0000, 1, 1);
    cyc("R7 after hi write", 0, '0, 0, 1);
    // R9: other addresses ignored
    for (int a = 2; a < 16; a++) cyc("R9 other wr", a, 16'h0000, 1, 0);
    cyc("R9 after other", 0, '0, 0, 1);
    // R8: reads outside 0/1 and idle
    for (int a = 2; a < 16; a++) cyc("R8 other rd", a, '0, 0, 1);
    cyc("R8 idle", 0, '0, 0, 0);
    // R6: junk in upper bits, enable only
    cyc("R6 junk wr", 0, 16'hFFF9, 1, 0);
    cyc("R6 after junk", 0, '0, 0, 1);
    // R2: enable then request toggling
    cyc("R2 en clr", 0, 16'hA002, 1, 1);
    cyc("R2 readback", 0, '0, 0, 1);
    cyc("R10 back-to-back", 0, 16'h0001, 1, 1);
    cyc("R10 back-to-back", 0, 16'h0003, 1, 1);
    cyc("R10 back-to-back", 0, 16'h0000, 1, 1);
    cyc("R2 final", 0, '0, 0, 1);
    // sweep all low-word patterns with simultaneous reads
    for (int v = 0; v < 64; v++)
      cyc("R10 sweep", v % 3, DATA_W'(v * 16'h0425), v[0], 1);

    // R1: reset again after a pending state
    cyc("R4 set", 0, 16'h0003, 1, 0);
    @(negedge clk); rst_n = 0; m_en = 0; m_req = 0; rd = 1; addr = '0; wr = 0;
    #(CLK_P/4);
    check("R1 async reset rdata", rdata, 16'h0000);
    check("R1 async reset stat_no", DATA_W'(stat_n), 16'h0001);
    @(negedge clk); rst_n = 1;
    cyc("R1 after second reset", 0, '0, 0, 1);
    finish_run();
  end
endmodule